// File: doc/BRIEF.md
# Synthetic Packet Traffic Source and Delivery Checker

This block sits at one node of a 16-node mesh network and loads it with synthetic traffic. In each cycle it is idle, the source compares a pseudo-random byte against a programmable injection rate to decide whether to open a packet. It then draws a random length from one to ten flits and a destination, and sends the packet as a head flit, body flits and a tail flit on a valid/ready port. The destination comes from one of two spatial patterns. In the uniform pattern it is random over every node except the node itself. In the complement pattern it is the bitwise inverse of the node address. All random values come from one linear feedback shift register.

On the receive side, a checker takes the flits that the network delivers to this node. It compares every flit against the fields that the header implies, and it tracks the next expected sequence number for each of the 16 possible sources. It keeps three counters: packets received intact, packets missing from a sequence, and packets that were corrupted, malformed or duplicated.

Flit encoding (bits 31:30 type): 01 head, 00 body, 10 tail, 11 single-flit packet. A head or single flit carries destination [29:26], source [25:22], sequence [21:14], length [13:10], and [9:0] equal to zero. A body or tail flit at position i (the head is position 0) carries source [29:26], sequence [25:18], i [17:14], the inverted sequence [13:6], the inverted source [5:2], and [1:0] equal to zero.

Top module: `noc_traffic_node`

## Requirements
- R1: While reset is held and on the first cycle after it, tx_valid is low and all three counters read zero.
- R2: With inj_rate equal to zero, an idle source never raises tx_valid; with a nonzero rate, packets do start.
- R3: Each packet is a head flit followed by length-1 further flits, the last of which is a tail, or is a single type-11 flit when the length is 1. The length lies in 1..10, and the fields follow the encoding above with the node's own address as source. Several different lengths occur.
- R4: With pattern_sel low, the destination never equals node_id, and many different destinations occur.
- R5: With pattern_sel high, the destination equals the bitwise inverse of node_id.
- R6: The sequence field of the source starts at 0 after reset and rises by one per packet, modulo 256.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_flit holds its value on the next cycle.
- R8: A received packet that is intact and in sequence raises good_pkts by one.
- R9: A head whose sequence number is k ahead of the one expected for its source (k below 128) adds k to lost_pkts and sets the expected number to one past the received one.
- R10: A head whose sequence number is behind the one expected (difference of 128 or more) marks the packet as bad and leaves the expectation for that source unchanged.
- R11: A body or tail flit that differs in any bit from the encoding implied by its header makes the packet count in bad_pkts, not in good_pkts.
- R12: A body or tail flit arriving with no packet open adds one to bad_pkts. A head arriving while a packet is open adds one to bad_pkts for the cut-off packet.
- R13: The counters change only on the cycle after a flit arrives on rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_id | input | 4 | Address of this node |
| pattern_sel | input | 1 | 0 uniform destinations, 1 complement destination |
| inj_rate | input | 8 | A packet starts when a random byte is below this value |
| tx_valid | output | 1 | Outgoing flit is valid |
| tx_ready | input | 1 | Network accepts the outgoing flit |
| tx_flit | output | 32 | Outgoing flit |
| rx_valid | input | 1 | Incoming flit is valid |
| rx_flit | input | 32 | Incoming flit |
| good_pkts | output | 16 | Intact packets received |
| lost_pkts | output | 16 | Packets missing from a source's sequence |
| bad_pkts | output | 16 | Corrupted, malformed or duplicate packets |

## Verification
The source's output is looped back into the checker while tx_ready is withheld at random. This is done in the uniform pattern and then in the complement pattern, so that framing, destination rule, sequence numbering and stall holding are all judged against a behavioural stream model. The lossless loop must move only good_pkts. Hand-built packets from a foreign source then cover, in turn, an in-order packet, a sequence jump, a replayed older number, a flipped body bit, a stray tail and a cut-off packet. Each of these moves a different counter by a known amount, which shows that the checker separates loss, duplication and corruption.

// File: rtl/noc_tg_pkg.sv
package noc_tg_pkg;
  localparam int ADDR_W = 4;
  localparam int SEQ_W  = 8;
  localparam int LEN_W  = 4;
  localparam int FLIT_W = 32;
  localparam int NODES  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } ftype_e;

  typedef logic [FLIT_W-1:0] flit_t;

  function automatic flit_t mk_head(ftype_e t, logic [ADDR_W-1:0] dst,
                                    logic [ADDR_W-1:0] src,
                                    logic [SEQ_W-1:0] seq,
                                    logic [LEN_W-1:0] len);
    return {t, dst, src, seq, len, 10'd0};
  endfunction

  function automatic flit_t mk_body(ftype_e t, logic [ADDR_W-1:0] src,
                                    logic [SEQ_W-1:0] seq,
                                    logic [LEN_W-1:0] idx);
    return {t, src, seq, idx, ~seq, ~src, 2'b00};
  endfunction
endpackage

// File: rtl/noc_tg_lfsr.sv
module noc_tg_lfsr #(
  parameter int W = 24,
  parameter logic [W-1:0] TAPS = 24'hE10000,
  parameter logic [W-1:0] SEED = 24'h5A3C71
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  // Galois form, shifting right; a zero seed is replaced so the register never locks.
  localparam logic [W-1:0] START = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;

  always_ff @(posedge clk) begin
    if (rst)           state <= START;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else               state <= state >> 1;
  end
endmodule

// File: rtl/noc_tg_source.sv
module noc_tg_source
  import noc_tg_pkg::*;
#(
  parameter int MAX_LEN = 10,
  parameter int RATE_W  = 8,
  parameter logic [3*RATE_W-1:0] TAPS = 24'hE10000,
  parameter logic [3*RATE_W-1:0] SEED = 24'h5A3C71
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] node_id,
  input  logic              pattern_sel,
  input  logic [RATE_W-1:0] inj_rate,
  input  logic              tx_ready,
  output logic              tx_valid,
  output flit_t             tx_flit
);
  localparam int RND_W  = RATE_W;
  localparam int LFSR_W = 3 * RND_W;
  localparam int LP_W   = RND_W + LEN_W;
  localparam int DP_W   = RND_W + ADDR_W;

  logic [LFSR_W-1:0] rnd;
  logic [RND_W-1:0]  r_inj, r_len, r_dst;
  logic [LP_W-1:0]   len_prod;
  logic [DP_W-1:0]   dst_prod;
  logic [LEN_W-1:0]  new_len;
  logic [ADDR_W-1:0] new_dst;
  logic              start;

  logic [LEN_W-1:0]  cur_len, cur_idx, nxt_idx;
  logic [SEQ_W-1:0]  seq_ctr;
  logic [ADDR_W-1:0] lat_src;

  noc_tg_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(rnd)
  );

  assign r_inj = rnd[RND_W-1:0];
  assign r_len = rnd[2*RND_W-1:RND_W];
  assign r_dst = rnd[3*RND_W-1:2*RND_W];

  // Scale a random byte into 0..MAX_LEN-1 and 0..NODES-2 by multiply and shift.
  assign len_prod = {{LEN_W{1'b0}}, r_len} * LP_W'(MAX_LEN);
  assign dst_prod = {{ADDR_W{1'b0}}, r_dst} * DP_W'(NODES - 1);
  assign new_len  = len_prod[RND_W +: LEN_W] + 1'b1;
  assign new_dst  = pattern_sel ? ~node_id
                                : node_id + dst_prod[RND_W +: ADDR_W] + 1'b1;
  assign start    = (r_inj < inj_rate);
  assign nxt_idx  = cur_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_flit  <= '0;
      cur_len  <= '0;
      cur_idx  <= '0;
      seq_ctr  <= '0;
      lat_src  <= '0;
    end else if (!tx_valid) begin
      if (start) begin
        tx_valid <= 1'b1;
        cur_len  <= new_len;
        cur_idx  <= '0;
        lat_src  <= node_id;
        tx_flit  <= mk_head((new_len == LEN_W'(1)) ? FT_SINGLE : FT_HEAD,
                            new_dst, node_id, seq_ctr, new_len);
      end
    end else if (tx_ready) begin
      if (cur_idx == cur_len - 1'b1) begin
        tx_valid <= 1'b0;
        seq_ctr  <= seq_ctr + 1'b1;
      end else begin
        cur_idx <= nxt_idx;
        tx_flit <= mk_body((nxt_idx == cur_len - 1'b1) ? FT_TAIL : FT_BODY,
                           lat_src, seq_ctr, nxt_idx);
      end
    end
  end

  // R7: a stalled flit is neither dropped nor altered.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit));

  // R2: a zero rate keeps an idle source idle.
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !tx_valid && inj_rate == '0 |=> !tx_valid);

  // R5: the complement pattern inverts the node address.
  p_cmpl_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) && $past(pattern_sel) |-> tx_flit[29:26] == ~$past(node_id));

  // R4: the uniform pattern never targets the node itself.
  p_notself_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) && !$past(pattern_sel) |-> tx_flit[29:26] != $past(node_id));

  // R3: header length stays within 1..MAX_LEN.
  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_flit[13:10] >= LEN_W'(1) && tx_flit[13:10] <= LEN_W'(MAX_LEN));
endmodule

// File: rtl/noc_tg_checker.sv
module noc_tg_checker
  import noc_tg_pkg::*;
#(
  parameter int MAX_LEN = 10,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  flit_t            rx_flit,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] lost_cnt,
  output logic [CNT_W-1:0] bad_cnt
);
  logic [SEQ_W-1:0] exp_seq [NODES];

  logic              open_q, bad_q;
  logic [ADDR_W-1:0] src_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [LEN_W-1:0]  len_q, idx_q;

  ftype_e            ftype;
  logic              is_head;
  logic [ADDR_W-1:0] h_src;
  logic [SEQ_W-1:0]  h_seq, diff;
  logic [LEN_W-1:0]  h_len;
  logic              behind, h_bad, b_bad;
  flit_t             exp_flit;
  logic              good_inc;
  logic [1:0]        bad_inc;
  logic [SEQ_W-1:0]  lost_add;

  always_comb begin
    ftype    = ftype_e'(rx_flit[31:30]);
    is_head  = (ftype == FT_HEAD) || (ftype == FT_SINGLE);
    h_src    = rx_flit[25:22];
    h_seq    = rx_flit[21:14];
    h_len    = rx_flit[13:10];
    diff     = h_seq - exp_seq[h_src];
    behind   = diff[SEQ_W-1];
    h_bad    = behind || (h_len == '0) || (h_len > LEN_W'(MAX_LEN)) ||
               (rx_flit[9:0] != '0) ||
               ((ftype == FT_SINGLE) != (h_len == LEN_W'(1)));
    exp_flit = mk_body((idx_q == len_q - 1'b1) ? FT_TAIL : FT_BODY, src_q, seq_q, idx_q);
    b_bad    = (rx_flit != exp_flit);

    good_inc = 1'b0;
    bad_inc  = 2'd0;
    lost_add = '0;
    if (rx_valid) begin
      if (is_head) begin
        if (open_q) bad_inc = bad_inc + 2'd1;
        if (!behind) lost_add = diff;
        if (ftype == FT_SINGLE) begin
          if (h_bad) bad_inc = bad_inc + 2'd1;
          else       good_inc = 1'b1;
        end
      end else if (!open_q) begin
        bad_inc = 2'd1;
      end else if (ftype == FT_TAIL) begin
        if (bad_q || b_bad) bad_inc = 2'd1;
        else                good_inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NODES; i++) exp_seq[i] <= '0;
    end else if (rx_valid && is_head && !behind) begin
      exp_seq[h_src] <= h_seq + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      bad_q    <= 1'b0;
      src_q    <= '0;
      seq_q    <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      good_cnt <= '0;
      lost_cnt <= '0;
      bad_cnt  <= '0;
    end else begin
      if (rx_valid) begin
        if (is_head) begin
          open_q <= (ftype == FT_HEAD);
          bad_q  <= h_bad;
          src_q  <= h_src;
          seq_q  <= h_seq;
          len_q  <= h_len;
          idx_q  <= LEN_W'(1);
        end else if (open_q) begin
          if (ftype == FT_TAIL) open_q <= 1'b0;
          idx_q <= idx_q + 1'b1;
          bad_q <= bad_q | b_bad;
        end
      end
      good_cnt <= good_cnt + CNT_W'(good_inc);
      bad_cnt  <= bad_cnt + CNT_W'(bad_inc);
      lost_cnt <= lost_cnt + CNT_W'(lost_add);
    end
  end

  // R13: counters move only after an arriving flit.
  p_still_r13: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(good_cnt) && $stable(lost_cnt) && $stable(bad_cnt));

  // R8: at most one intact packet completes per flit.
  p_good_step_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> good_cnt == $past(good_cnt) || good_cnt == $past(good_cnt) + 1'b1);

  // R12: one flit can condemn at most the cut-off packet and itself.
  p_bad_step_r12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> bad_cnt - $past(bad_cnt) <= CNT_W'(2));
endmodule

// File: rtl/noc_traffic_node.sv
module noc_traffic_node
  import noc_tg_pkg::*;
#(
  parameter int MAX_LEN = 10,
  parameter int RATE_W  = 8,
  parameter int CNT_W   = 16,
  parameter logic [3*RATE_W-1:0] TAPS = 24'hE10000,
  parameter logic [3*RATE_W-1:0] SEED = 24'h5A3C71
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        node_id,
  input  logic              pattern_sel,
  input  logic [RATE_W-1:0] inj_rate,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_flit,
  input  logic              rx_valid,
  input  logic [31:0]       rx_flit,
  output logic [CNT_W-1:0]  good_pkts,
  output logic [CNT_W-1:0]  lost_pkts,
  output logic [CNT_W-1:0]  bad_pkts
);
  noc_tg_source #(
    .MAX_LEN(MAX_LEN), .RATE_W(RATE_W), .TAPS(TAPS), .SEED(SEED)
  ) u_src (
    .clk(clk), .rst(rst), .node_id(node_id), .pattern_sel(pattern_sel),
    .inj_rate(inj_rate), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_flit(tx_flit)
  );

  noc_tg_checker #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_flit(rx_flit),
    .good_cnt(good_pkts), .lost_cnt(lost_pkts), .bad_cnt(bad_pkts)
  );

  // R1: nothing is offered and nothing is counted right after reset.
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !tx_valid && good_pkts == '0 && lost_pkts == '0 && bad_pkts == '0);
endmodule

// File: tb/sim_noc_traffic_node.sv
module sim_noc_traffic_node;
  localparam logic [3:0] NODE = 4'd6;
  localparam logic [3:0] FOREIGN = 4'd3;

  logic        clk = 1'b0;
  logic        rst, pattern_sel, tx_ready, rx_valid, tx_valid;
  logic [3:0]  node_id;
  logic [7:0]  inj_rate;
  logic [31:0] tx_flit, rx_flit;
  logic [15:0] good_pkts, lost_pkts, bad_pkts;

  int checks = 0, errors = 0;
  int exp_good = 0, exp_lost = 0, exp_bad = 0;
  // stream model of the source
  bit in_pkt = 0;
  int m_idx, m_len, m_seq, tx_seq = 0, pkts = 0;
  bit [15:0] dst_seen = '0;
  bit [15:0] len_seen = '0;
  bit pv, pr;
  logic [31:0] pf;

  noc_traffic_node u0 (
    .clk(clk), .rst(rst), .node_id(node_id), .pattern_sel(pattern_sel),
    .inj_rate(inj_rate), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit),
    .rx_valid(rx_valid), .rx_flit(rx_flit), .good_pkts(good_pkts),
    .lost_pkts(lost_pkts), .bad_pkts(bad_pkts)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  function automatic logic [31:0] hdr(logic [1:0] t, logic [3:0] d, logic [3:0] s,
                                      logic [7:0] q, logic [3:0] l);
    return {t, d, s, q, l, 10'd0};
  endfunction

  function automatic logic [31:0] bdy(logic [1:0] t, logic [3:0] s, logic [7:0] q,
                                      logic [3:0] i);
    return {t, s, q, i, ~q, ~s, 2'b00};
  endfunction

  // One clock: snapshot pre-edge values, move to the next falling edge, compare.
  task automatic tick();
    pv = tx_valid; pr = tx_ready; pf = tx_flit;
    @(negedge clk);
    // R13: per-clock comparison of all three counters with the model
    chk(good_pkts == 16'(exp_good) && lost_pkts == 16'(exp_lost) && bad_pkts == 16'(exp_bad),
        "R13 counters", {good_pkts, lost_pkts, bad_pkts}, {16'(exp_good), 16'(exp_lost), 16'(exp_bad)});
    if (pv && !pr) chk(tx_valid && tx_flit == pf, "R7 stall hold", tx_flit, pf);
  endtask

  task automatic parse(logic [31:0] f);
    logic [1:0] t;
    logic [3:0] l;
    t = f[31:30];
    if (!in_pkt) begin
      l = f[13:10];
      chk(t == 2'b01 || t == 2'b11, "R3 head type", t, 1);
      chk(f[25:22] == NODE && f[9:0] == 0, "R3 head fields", f[25:22], NODE);
      chk(f[21:14] == 8'(tx_seq), "R6 sequence", f[21:14], 8'(tx_seq));
      chk(l >= 1 && l <= 10, "R3 length range", l, 10);
      chk((t == 2'b11) == (l == 1), "R3 single iff len 1", t, l);
      len_seen[l] = 1'b1;
      if (!pattern_sel) begin
        chk(f[29:26] != NODE, "R4 not self", f[29:26], NODE);
        dst_seen[f[29:26]] = 1'b1;
      end else begin
        chk(f[29:26] == ~NODE, "R5 complement", f[29:26], ~NODE);
      end
      if (l <= 1) begin
        tx_seq++; pkts++; exp_good++;
      end else begin
        in_pkt = 1; m_idx = 1; m_len = l; m_seq = tx_seq;
      end
    end else begin
      logic [31:0] e;
      e = bdy((m_idx == m_len - 1) ? 2'b10 : 2'b00, NODE, 8'(m_seq), 4'(m_idx));
      chk(f == e, "R3 body flit", f, e);
      if (m_idx == m_len - 1) begin
        in_pkt = 0; tx_seq++; pkts++; exp_good++;
      end else m_idx++;
    end
  endtask

  task automatic lb_cycle(bit rdy);
    tick();
    tx_ready = rdy;
    if (tx_valid && rdy) begin
      parse(tx_flit);
      rx_valid = 1'b1;
      rx_flit  = tx_flit;
    end else rx_valid = 1'b0;
  endtask

  task automatic send(logic [31:0] f);
    tick();
    rx_valid = 1'b1;
    rx_flit  = f;
  endtask

  task automatic quiet();
    tick();
    rx_valid = 1'b0;
  endtask

  initial begin
    int seen_valid;
    rst = 1'b1; node_id = NODE; pattern_sel = 1'b0; inj_rate = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_flit = '0;
    repeat (4) @(negedge clk);
    chk(!tx_valid && good_pkts == 0 && lost_pkts == 0 && bad_pkts == 0, "R1 in reset", tx_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && good_pkts == 0 && lost_pkts == 0 && bad_pkts == 0, "R1 after reset", tx_valid, 0);

    // R2: zero rate keeps the source idle
    seen_valid = 0;
    for (int i = 0; i < 200; i++) begin
      lb_cycle(1'b1);
      if (tx_valid) seen_valid++;
    end
    chk(seen_valid == 0, "R2 zero rate", seen_valid, 0);

    // uniform pattern, random back-pressure
    inj_rate = 8'd100;
    for (int i = 0; i < 20000 && pkts < 40; i++) lb_cycle(($urandom % 4) != 0);
    chk(pkts >= 40, "R2 packets injected", pkts, 40);
    inj_rate = '0;
    for (int i = 0; i < 40; i++) lb_cycle(1'b1);
    chk($countones(dst_seen) >= 8, "R4 destination spread", $countones(dst_seen), 8);
    chk(dst_seen[NODE] == 1'b0, "R4 own address unused", dst_seen[NODE], 0);

    // complement pattern
    pattern_sel = 1'b1;
    inj_rate = 8'd200;
    for (int i = 0; i < 20000 && pkts < 80; i++) lb_cycle(($urandom % 3) != 0);
    chk(pkts >= 80, "R5 packets injected", pkts, 80);
    inj_rate = '0;
    for (int i = 0; i < 40; i++) lb_cycle(1'b1);
    chk($countones(len_seen) >= 5, "R3 length spread", $countones(len_seen), 5);
    chk(!tx_valid && !in_pkt, "R3 stream closed", tx_valid, 0);
    chk(lost_pkts == 0 && bad_pkts == 0, "R8 loopback clean", bad_pkts, 0);
    tx_ready = 1'b0;

    // R8: intact in-order packet from a foreign source
    send(hdr(2'b01, NODE, FOREIGN, 8'd0, 4'd3));
    send(bdy(2'b00, FOREIGN, 8'd0, 4'd1));
    send(bdy(2'b10, FOREIGN, 8'd0, 4'd2)); exp_good++;
    quiet();
    chk(good_pkts == 16'(exp_good), "R8 good packet", good_pkts, exp_good);

    // R9: jump from expected 1 to 3 loses two packets
    send(hdr(2'b11, NODE, FOREIGN, 8'd3, 4'd1)); exp_good++; exp_lost += 2;
    quiet();
    chk(lost_pkts == 16'(exp_lost), "R9 gap counted", lost_pkts, exp_lost);

    // R10: replayed older number is bad; expectation stays at 4
    send(hdr(2'b01, NODE, FOREIGN, 8'd2, 4'd2));
    send(bdy(2'b10, FOREIGN, 8'd2, 4'd1)); exp_bad++;
    quiet();
    chk(bad_pkts == 16'(exp_bad) && lost_pkts == 16'(exp_lost), "R10 duplicate", bad_pkts, exp_bad);
    send(hdr(2'b11, NODE, FOREIGN, 8'd4, 4'd1)); exp_good++;
    quiet();
    chk(good_pkts == 16'(exp_good) && lost_pkts == 16'(exp_lost), "R10 expectation kept", lost_pkts, exp_lost);

    // R11: flipped body bit
    send(hdr(2'b01, NODE, FOREIGN, 8'd5, 4'd3));
    send(bdy(2'b00, FOREIGN, 8'd5, 4'd1) ^ 32'h1);
    send(bdy(2'b10, FOREIGN, 8'd5, 4'd2)); exp_bad++;
    quiet();
    chk(bad_pkts == 16'(exp_bad) && good_pkts == 16'(exp_good), "R11 corruption", bad_pkts, exp_bad);

    // R12: stray tail, then a packet cut off by a new head
    send(bdy(2'b10, FOREIGN, 8'd9, 4'd1)); exp_bad++;
    quiet();
    chk(bad_pkts == 16'(exp_bad), "R12 stray tail", bad_pkts, exp_bad);
    send(hdr(2'b01, NODE, FOREIGN, 8'd6, 4'd3));
    send(bdy(2'b00, FOREIGN, 8'd6, 4'd1));
    send(hdr(2'b11, NODE, FOREIGN, 8'd7, 4'd1)); exp_bad++; exp_good++;
    quiet();
    chk(bad_pkts == 16'(exp_bad) && good_pkts == 16'(exp_good), "R12 cut-off packet", bad_pkts, exp_bad);
    for (int i = 0; i < 4; i++) quiet();
    summary();
  end
endmodule